// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken by running two direction predictors side by side and choosing between them for each lookup. The global side keeps one register of recent outcomes across all branches and uses it to index a table of 2-bit counters. The local side keeps a short outcome history per branch slot, addressed by the branch address. That history then indexes a table of 3-bit counters. A third table of 2-bit counters, also addressed by the global history, decides which of the two guesses is output.

A fetch stage presents a branch address on the lookup port and gets back a direction and an indication of which side supplied it, in the same cycle. When the branch resolves, the address and real outcome are presented on the training port. On that clock edge both sides learn the outcome, the chooser learns which side deserved the call, and both histories take the new outcome. Table sizes follow the history widths, so they shrink for simulation.

Top module: `tourney_pred`

## Requirements
- R1: After reset every history is all zeros, each global counter holds 1, each local counter holds 3 and each chooser counter holds 1, so every lookup returns not taken from the global side (predTaken=0, predUseLocal=0).
- R2: predUseLocal is 1 when the chooser counter at the current global history is 2 or 3; predTaken then equals the local guess, otherwise the global guess. Both outputs are combinational from predPc and the stored state.
- R3: The global guess is taken when the 2-bit counter indexed by the global history is 2 or more.
- R4: The local guess uses the history entry selected by predPc bits [OFS_W +: LHT_W] to index a 3-bit counter, and is taken when that counter is 4 or more.
- R5: On a clock edge with updValid=1, the global counter indexed by the pre-edge global history steps up by one if updTaken=1 and down by one otherwise, holding at 0 and 3.
- R6: On the same edge, the local counter indexed by the history entry of updPc steps toward the outcome, holding at 0 and 7.
- R7: The chooser counter at the pre-edge global history steps up (toward local) when only the local guess for updPc matched the outcome, steps down when only the global guess matched, and stays put when both guesses agree; it holds at 0 and 3.
- R8: On an update the outcome enters bit 0 of the global history and of the local history entry selected by updPc, older bits moving up one place and the oldest dropping out.
- R9: With updValid=0 no table or history changes on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| predPc | input | PC_W | Branch address to look up |
| predTaken | output | 1 | Guessed direction, 1 = taken |
| predUseLocal | output | 1 | 1 when the local side supplied the guess |
| updValid | input | 1 | Training strobe for a resolved branch |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Real outcome, 1 = taken |

## Verification
The bench builds the predictor with a 4-bit global history, eight local history slots, 4-bit local histories and a 16-bit address. These sizes give 16 global and chooser counters and 16 local counters. A few hundred updates then drive counters into both saturation limits, swing the chooser across to the local side and back, and make several branch addresses alias onto shared slots. A behavioural model with plain integer arrays is compared against both outputs every cycle. The run covers one repeating loop branch, a pair of correlated branches, random traffic and idle stretches.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef struct packed {
    logic trainGlobal;
    logic trainLocal;
    logic towardLocal;
    logic towardGlobal;
    logic shiftHist;
  } tpStrobes_t;

  function automatic logic [1:0] step2(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? v : v + 2'd1;
    else    return (v == 2'd0) ? v : v - 2'd1;
  endfunction

  function automatic logic [2:0] step3(input logic [2:0] v, input logic up);
    if (up) return (v == 3'd7) ? v : v + 3'd1;
    else    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

endpackage

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       updValid,
  input  logic       updTaken,
  input  logic       updGlobal,
  input  logic       updLocal,
  output tpStrobes_t st
);

  logic globalRight;
  logic localRight;

  always_comb begin
    globalRight     = (updGlobal == updTaken);
    localRight      = (updLocal == updTaken);
    st              = '0;
    st.trainGlobal  = updValid;
    st.trainLocal   = updValid;
    st.shiftHist    = updValid;
    st.towardLocal  = updValid && localRight && !globalRight;
    st.towardGlobal = updValid && globalRight && !localRight;
  end

  // R7
  agree_no_choose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updGlobal == updLocal) |-> !(st.towardLocal || st.towardGlobal));

  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updValid |-> (st == '0));

endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int OFS_W   = 2,
  parameter int GHIST_W = 12,
  parameter int LHT_W   = 10,
  parameter int LHIST_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] predPc,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  tpStrobes_t      st,
  output logic            predTaken,
  output logic            predUseLocal,
  output logic            updGlobal,
  output logic            updLocal
);

  localparam int G_N  = 1 << GHIST_W;
  localparam int LT_N = 1 << LHT_W;
  localparam int LC_N = 1 << LHIST_W;

  logic [1:0]         gCnt  [G_N];
  logic [1:0]         chCnt [G_N];
  logic [2:0]         lCnt  [LC_N];
  logic [LHIST_W-1:0] lHist [LT_N];
  logic [GHIST_W-1:0] gHist;

  logic [LHT_W-1:0]   predSlot, updSlot;
  logic [LHIST_W-1:0] predLh, updLh;
  logic               predG, predL;

  always_comb begin
    predSlot     = predPc[OFS_W +: LHT_W];
    updSlot      = updPc[OFS_W +: LHT_W];
    predLh       = lHist[predSlot];
    updLh        = lHist[updSlot];
    predG        = gCnt[gHist][1];
    predL        = lCnt[predLh][2];
    predUseLocal = chCnt[gHist][1];
    predTaken    = predUseLocal ? predL : predG;
    updGlobal    = gCnt[gHist][1];
    updLocal     = lCnt[updLh][2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gHist <= '0;
      for (int i = 0; i < G_N; i++) begin
        gCnt[i]  <= 2'd1;
        chCnt[i] <= 2'd1;
      end
      for (int i = 0; i < LC_N; i++) lCnt[i] <= 3'd3;
      for (int i = 0; i < LT_N; i++) lHist[i] <= '0;
    end else begin
      if (st.trainGlobal) gCnt[gHist] <= step2(gCnt[gHist], updTaken);
      if (st.trainLocal)  lCnt[updLh] <= step3(lCnt[updLh], updTaken);
      if (st.towardLocal)
        chCnt[gHist] <= step2(chCnt[gHist], 1'b1);
      else if (st.towardGlobal)
        chCnt[gHist] <= step2(chCnt[gHist], 1'b0);
      if (st.shiftHist) begin
        gHist          <= {gHist[GHIST_W-2:0], updTaken};
        lHist[updSlot] <= {updLh[LHIST_W-2:0], updTaken};
      end
    end
  end

  // R8
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.shiftHist |=> gHist == {$past(gHist[GHIST_W-2:0]), $past(updTaken)});

  // R9
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st.shiftHist |=> $stable(gHist));

  // R5
  gcnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.trainGlobal && updTaken && gCnt[gHist] == 2'd3)
      |=> gCnt[$past(gHist)] == 2'd3);

  // R6
  lcnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.trainLocal && !updTaken && lCnt[updLh] == 3'd0)
      |=> lCnt[$past(updLh)] == 3'd0);

endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int OFS_W   = 2,
  parameter int GHIST_W = 12,
  parameter int LHT_W   = 10,
  parameter int LHIST_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  output logic            predUseLocal,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  tpStrobes_t st;
  logic       updGlobal, updLocal;

  tp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .updValid  (updValid),
    .updTaken  (updTaken),
    .updGlobal (updGlobal),
    .updLocal  (updLocal),
    .st        (st)
  );

  tp_datapath #(
    .PC_W    (PC_W),
    .OFS_W   (OFS_W),
    .GHIST_W (GHIST_W),
    .LHT_W   (LHT_W),
    .LHIST_W (LHIST_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .predPc       (predPc),
    .updPc        (updPc),
    .updTaken     (updTaken),
    .st           (st),
    .predTaken    (predTaken),
    .predUseLocal (predUseLocal),
    .updGlobal    (updGlobal),
    .updLocal     (updLocal)
  );

endmodule

// File: tb/sim_tourney_pred.sv
`timescale 1ns/1ps
module sim_tourney_pred;

  localparam int PC_W = 16, OFS_W = 2, GW = 4, LTW = 3, LHW = 4;
  localparam int GN = 1 << GW, LTN = 1 << LTW, LCN = 1 << LHW;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] predPc = '0, updPc = '0;
  logic updValid = 0, updTaken = 0;
  logic predTaken, predUseLocal;

  tourney_pred #(.PC_W(PC_W), .OFS_W(OFS_W), .GHIST_W(GW), .LHT_W(LTW), .LHIST_W(LHW)) u0 (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .predTaken(predTaken),
    .predUseLocal(predUseLocal), .updValid(updValid), .updPc(updPc), .updTaken(updTaken));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  int mG[GN], mC[GN], mL[LCN], mH[LTN], mGh;

  function automatic int slotOf(logic [PC_W-1:0] pc);
    return (pc >> OFS_W) & (LTN - 1);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < GN; i++) begin mG[i] = 1; mC[i] = 1; end
    for (int i = 0; i < LCN; i++) mL[i] = 3;
    for (int i = 0; i < LTN; i++) mH[i] = 0;
    mGh = 0;
  endtask

  task automatic modelUpdate(logic [PC_W-1:0] pc, bit t);
    int s, h; bit gp, lp;
    s = slotOf(pc); h = mH[s];
    gp = mG[mGh] >= 2; lp = mL[h] >= 4;
    mG[mGh] = t ? (mG[mGh] < 3 ? mG[mGh] + 1 : 3) : (mG[mGh] > 0 ? mG[mGh] - 1 : 0);
    mL[h] = t ? (mL[h] < 7 ? mL[h] + 1 : 7) : (mL[h] > 0 ? mL[h] - 1 : 0);
    if (gp != lp) begin
      if (lp == t) mC[mGh] = (mC[mGh] < 3) ? mC[mGh] + 1 : 3;
      else         mC[mGh] = (mC[mGh] > 0) ? mC[mGh] - 1 : 0;
    end
    mH[s] = ((h << 1) | int'(t)) & (LCN - 1);
    mGh = ((mGh << 1) | int'(t)) & (GN - 1);
  endtask

  task automatic checkOut(string tag);
    bit eUse, eTk;
    eUse = mC[mGh] >= 2;
    eTk = eUse ? (mL[mH[slotOf(predPc)]] >= 4) : (mG[mGh] >= 2);
    checks++;
    if (predUseLocal !== eUse || predTaken !== eTk) begin
      fails++;
      $display("FAIL %s: pc=%h taken/useLocal actual=%b/%b expected=%b/%b",
               tag, predPc, predTaken, predUseLocal, eTk, eUse);
    end
  endtask

  // drive one cycle: inputs at negedge, compare after settle, advance model at posedge
  task automatic cyc(logic [PC_W-1:0] pp, bit v, logic [PC_W-1:0] up, bit t, string tag);
    @(negedge clk);
    predPc = pp; updValid = v; updPc = up; updTaken = t;
    #1 checkOut(tag);
    @(posedge clk);
    if (v) modelUpdate(up, t);
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state across several addresses
    for (int i = 0; i < 8; i++) cyc(16'(i * 4), 0, '0, 0, "R1 reset state");
    // R5 R3 saturate global side with always-taken branch, then drain
    for (int i = 0; i < 12; i++) cyc(16'h0040, 1, 16'h0040, 1, "R5 R3 global saturate up");
    for (int i = 0; i < 12; i++) cyc(16'h0040, 1, 16'h0040, 0, "R5 R3 global saturate down");
    // R6 R4 R8 loop branch, pattern taken x3 then not taken
    for (int i = 0; i < 80; i++) cyc(16'h0100, 1, 16'h0100, (i % 4) != 3, "R4 R6 R8 loop pattern");
    // R7 R2 correlated pair: second branch follows the first
    for (int i = 0; i < 60; i++) begin
      bit a; a = (i / 3) % 2;
      cyc(16'h0204, 1, 16'h0200, a, "R7 R2 correlated first");
      cyc(16'h0200, 1, 16'h0204, a, "R7 R2 correlated second");
    end
    // R9 idle with changing lookups and garbage on the update pins
    for (int i = 0; i < 20; i++)
      cyc(16'(i * 4), 0, 16'($urandom), 1'($urandom), "R9 idle holds state");
    // R2 R7 R8 random traffic over a small address set
    for (int i = 0; i < 600; i++) begin
      logic [PC_W-1:0] pc; bit t;
      pc = 16'(($urandom % 12) * 4);
      t = (pc[3] ^ (i % 5 == 0)) ? 1'b1 : 1'($urandom);
      cyc(16'(($urandom % 12) * 4), ($urandom % 4) != 0, pc, t, "R2 R3 R4 R7 R8 random");
    end
    // R9 final idle
    for (int i = 0; i < 16; i++) cyc(16'(i * 4), 0, 16'hffff, 1, "R9 idle holds state");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule